// File: doc/BRIEF.md
# Thread Vector Block Scheduler

This block keeps, for every basic block of a data-parallel kernel, a bit vector of the threads that must run that block next. It also decides which block the execution fabric runs. A start command places every thread in the entry block, which has ID 0. While a block is current, each batch request takes the lowest non-empty 64-bit word of that block's vector and turns it into one packet. The packet holds a 16-bit base thread ID and a 64-bit bitmap, and the read clears the word.

When the fabric finishes a batch, it returns up to two batches, one for each successor block. Each returned batch is ORed into the vector of its destination block, so threads that reach a block along different control paths end up in the same vector. A returned batch can instead retire its threads when the kernel ends for them.

A block stays current until its vector is empty and every thread dispatched from it has come back. The scheduler then moves to the lowest-numbered non-empty block. Because that block can have a lower ID than the one just finished, loops work with no extra logic. The vectors are stored across interleaved banks, each with one read port and one write port, so a dispatch and a merge can take place in the same cycle.

Top module: `cvt_sched`

## Requirements
- R1: After reset, busy_o, done_o and pkt_valid_o are 0 and cur_blk_o is 0.
- R2: A start_i pulse while busy_o is 0 places every one of the NUM_THREADS threads in block 0. In the next cycle busy_o is 1, done_o is 0 and cur_blk_o is 0.
- R3: A req_i while the current block has a non-empty word produces exactly one packet, with pkt_valid_o high in the following cycle. The packet is for the lowest-indexed non-empty word w: pkt_base_o = w*64, and bit i of pkt_map_o stands for thread pkt_base_o+i. The read empties the word. A req_i when no word is non-empty produces no packet.
- R4: All-zero words are skipped. A packet never carries an all-zero bitmap.
- R5: A returned batch with ret_exit_i = 0 is ORed into one word of block ret_blk_i. The word index is ret_base_i bits [15:6], and ret_base_i bits [5:0] are zero. Batches from several paths into the same word merge.
- R6: The current block does not change while it has a non-empty word, a packet in flight, or dispatched threads that have not yet returned.
- R7: When the current block finishes, the next current block is the lowest-numbered non-empty block. This includes blocks numbered below the finished one, which is how loops work.
- R8: If a returned batch targets the word being read in the same cycle, the packet carries the union of the stored and returned bits, and the word ends empty.
- R9: A returned batch with ret_exit_i = 1 retires its threads. Once the current block finishes and no block is non-empty, busy_o goes to 0 and done_o goes to 1 and stays there until the next start.
- R10: start_i while busy_o is 1 is ignored. It adds no threads to block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch the kernel: fill block 0 with all threads |
| req_i | input | 1 | Request one batch of the current block |
| pkt_valid_o | output | 1 | Batch packet valid |
| pkt_base_o | output | 16 | First thread ID of the batch |
| pkt_map_o | output | 64 | Threads of the batch, bit i = base+i |
| ret_valid_i | input | 1 | Returned batch valid |
| ret_exit_i | input | 1 | Returned threads leave the kernel |
| ret_blk_i | input | 3 | Destination block ID |
| ret_base_i | input | 16 | First thread ID of the returned batch |
| ret_map_i | input | 64 | Returned threads |
| cur_blk_o | output | 3 | Block currently scheduled |
| busy_o | output | 1 | Kernel running |
| done_o | output | 1 | Kernel finished |

## Verification
The assertions take the returned batches to be well formed. Each base is 64-aligned and inside the thread range. A returned batch never carries more threads than are outstanding plus those in the packet now on the output. Returns arrive only while the kernel runs.

The stimulus keeps within these rules by deriving every returned batch from threads that were actually dispatched. Each dispatched thread is routed to exactly one successor, either through a loop back into a block or through an exit. The same-cycle merge case is reached by splitting one dispatched word's threads into two returns, the second of which coincides with the read of that word.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

   localparam int unsigned LANE_BITS = 64;

   function automatic logic [6:0] lane_pop(input logic [LANE_BITS-1:0] v);
      logic [6:0] n;
      n = '0;
      for (int i = 0; i < LANE_BITS; i++) n = n + 7'(v[i]);
      return n;
   endfunction

endpackage

// File: rtl/cvt_lowest.sv
module cvt_lowest #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   generate
      if (N == 1) begin : g_single
         assign any_o = req_i[0];
         assign idx_o = '0;
      end else begin : g_multi
         always_comb begin
            any_o = 1'b0;
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) begin
                  any_o = 1'b1;
                  idx_o = IW'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cvt_bank.sv
module cvt_bank #(
   parameter int ROWS      = 8,
   parameter int FILL_ROWS = 1,
   parameter int DW        = 64,
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill_i,
   input  logic          rd_en_i,
   input  logic [RW-1:0] rd_row_i,
   output logic [DW-1:0] rd_data_o,
   input  logic          wr_en_i,
   input  logic [RW-1:0] wr_row_i,
   input  logic [DW-1:0] wr_data_i
);
   logic [DW-1:0] mem [ROWS];
   logic [DW-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) mem[r] <= '0;
         rd_q <= '0;
      end else begin
         if (fill_i)
            for (int r = 0; r < FILL_ROWS; r++) mem[r] <= '1;
         if (wr_en_i)
            mem[wr_row_i] <= mem[wr_row_i] | wr_data_i;
         if (rd_en_i) begin
            mem[rd_row_i] <= '0;
            rd_q <= mem[rd_row_i] |
                    ((wr_en_i && (wr_row_i == rd_row_i)) ? wr_data_i : '0);
         end
      end
   end

   assign rd_data_o = rd_q;

   // R3
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i |=> (mem[$past(rd_row_i)] == '0));
endmodule

// File: rtl/cvt_occupancy.sv
module cvt_occupancy #(
   parameter int NBLK = 8,
   parameter int WPB  = 8,
   localparam int TOT = NBLK * WPB,
   localparam int XW  = (TOT > 1) ? $clog2(TOT) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fill_i,
   input  logic            set_en_i,
   input  logic [XW-1:0]   set_idx_i,
   input  logic            clr_en_i,
   input  logic [XW-1:0]   clr_idx_i,
   output logic [TOT-1:0]  nz_o,
   output logic [NBLK-1:0] blk_nz_o
);
   logic [TOT-1:0] nz_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nz_q <= '0;
      end else begin
         if (fill_i) nz_q[WPB-1:0] <= '1;
         if (set_en_i) nz_q[set_idx_i] <= 1'b1;
         if (clr_en_i) nz_q[clr_idx_i] <= 1'b0;
      end
   end

   assign nz_o = nz_q;

   genvar b;
   generate
      for (b = 0; b < NBLK; b++) begin : g_blk
         assign blk_nz_o[b] = |nz_q[b*WPB +: WPB];
      end
   endgenerate
endmodule

// File: rtl/cvt_sched.sv
module cvt_sched #(
   parameter int NUM_BLOCKS  = 8,
   parameter int NUM_THREADS = 512,
   parameter int NUM_BANKS   = 8,
   parameter int WORD_W      = 64,
   parameter int TID_W       = 16,
   localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              req_i,
   output logic              pkt_valid_o,
   output logic [TID_W-1:0]  pkt_base_o,
   output logic [WORD_W-1:0] pkt_map_o,
   input  logic              ret_valid_i,
   input  logic              ret_exit_i,
   input  logic [BLK_W-1:0]  ret_blk_i,
   input  logic [TID_W-1:0]  ret_base_i,
   input  logic [WORD_W-1:0] ret_map_i,
   output logic [BLK_W-1:0]  cur_blk_o,
   output logic              busy_o,
   output logic              done_o
);
   import cvt_pkg::*;

   localparam int WPB   = NUM_THREADS / WORD_W;
   localparam int RPB   = WPB / NUM_BANKS;
   localparam int ROWS  = NUM_BLOCKS * RPB;
   localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int WI_W  = (WPB > 1) ? $clog2(WPB) : 1;
   localparam int BK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int TOT   = NUM_BLOCKS * WPB;
   localparam int XW    = (TOT > 1) ? $clog2(TOT) : 1;
   localparam int OFS   = $clog2(WORD_W);
   localparam int CNT_W = $clog2(NUM_THREADS + 1) + 1;

   generate
      if (WORD_W != LANE_BITS) begin : g_bad_word
         $error("WORD_W must equal the lane width");
      end
      if (NUM_BANKS < 1 || (NUM_THREADS % (WORD_W * NUM_BANKS)) != 0) begin : g_bad_bank
         $error("NUM_THREADS must be a multiple of WORD_W*NUM_BANKS");
      end
      if (NUM_THREADS > (1 << TID_W)) begin : g_bad_tid
         $error("TID_W too narrow for NUM_THREADS");
      end
      if (NUM_BLOCKS < 2) begin : g_bad_blk
         $error("NUM_BLOCKS must be at least 2");
      end
   endgenerate

   logic              running_q, done_q;
   logic [BLK_W-1:0]  cur_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pkt_v_q;
   logic [BK_W-1:0]   pkt_bank_q;
   logic [TID_W-1:0]  pkt_base_q;

   logic [TOT-1:0]        nz;
   logic [NUM_BLOCKS-1:0] blk_nz;
   logic [WPB-1:0]        cur_words;
   logic                  w_any, b_any;
   logic [WI_W-1:0]       w_sel;
   logic [BLK_W-1:0]      b_sel;

   logic              start_go, disp, r_go, fin;
   logic [WI_W-1:0]   r_word;
   int                d_bank, d_row, r_bank, r_row;
   logic [WORD_W-1:0] bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] rd_en, wr_en;

   assign cur_words = nz[int'(cur_q) * WPB +: WPB];

   cvt_lowest #(.N(WPB)) u_wsel (
      .req_i (cur_words),
      .any_o (w_any),
      .idx_o (w_sel)
   );

   cvt_lowest #(.N(NUM_BLOCKS)) u_bsel (
      .req_i (blk_nz),
      .any_o (b_any),
      .idx_o (b_sel)
   );

   assign start_go = start_i && !running_q;
   assign disp     = running_q && req_i && w_any;
   assign r_word   = ret_base_i[OFS +: WI_W];
   assign r_go     = running_q && ret_valid_i && !ret_exit_i;
   assign fin      = running_q && !w_any && !pkt_v_q && (cnt_q == '0) && !ret_valid_i;

   always_comb begin
      d_bank = int'(w_sel) % NUM_BANKS;
      d_row  = int'(cur_q) * RPB + int'(w_sel) / NUM_BANKS;
      r_bank = int'(r_word) % NUM_BANKS;
      r_row  = int'(ret_blk_i) * RPB + int'(r_word) / NUM_BANKS;
   end

   cvt_occupancy #(.NBLK(NUM_BLOCKS), .WPB(WPB)) u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_i    (start_go),
      .set_en_i  (r_go && (ret_map_i != '0)),
      .set_idx_i (XW'(int'(ret_blk_i) * WPB + int'(r_word))),
      .clr_en_i  (disp),
      .clr_idx_i (XW'(int'(cur_q) * WPB + int'(w_sel))),
      .nz_o      (nz),
      .blk_nz_o  (blk_nz)
   );

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign rd_en[b] = disp && (d_bank == b);
         assign wr_en[b] = r_go && (r_bank == b);
         cvt_bank #(.ROWS(ROWS), .FILL_ROWS(RPB), .DW(WORD_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_i    (start_go),
            .rd_en_i   (rd_en[b]),
            .rd_row_i  (ROW_W'(d_row)),
            .rd_data_o (bank_rd[b]),
            .wr_en_i   (wr_en[b]),
            .wr_row_i  (ROW_W'(r_row)),
            .wr_data_i (ret_map_i)
         );
      end
   endgenerate

   assign pkt_valid_o = pkt_v_q;
   assign pkt_base_o  = pkt_base_q;
   assign pkt_map_o   = bank_rd[pkt_bank_q];

   logic [CNT_W-1:0] cnt_add, cnt_sub;
   assign cnt_add = pkt_v_q ? CNT_W'(lane_pop(pkt_map_o)) : '0;
   assign cnt_sub = (running_q && ret_valid_i) ? CNT_W'(lane_pop(ret_map_i)) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q  <= 1'b0;
         done_q     <= 1'b0;
         cur_q      <= '0;
         cnt_q      <= '0;
         pkt_v_q    <= 1'b0;
         pkt_bank_q <= '0;
         pkt_base_q <= '0;
      end else begin
         pkt_v_q <= disp;
         if (disp) begin
            pkt_bank_q <= BK_W'(d_bank);
            pkt_base_q <= TID_W'(int'(w_sel) * WORD_W);
         end
         if (start_go) begin
            running_q <= 1'b1;
            done_q    <= 1'b0;
            cur_q     <= '0;
            cnt_q     <= '0;
         end else if (running_q) begin
            cnt_q <= cnt_q + cnt_add - cnt_sub;
            if (fin) begin
               if (b_any) begin
                  cur_q <= b_sel;
               end else begin
                  running_q <= 1'b0;
                  done_q    <= 1'b1;
               end
            end
         end
      end
   end

   assign cur_blk_o = cur_q;
   assign busy_o    = running_q;
   assign done_o    = done_q;

   // R2
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !running_q) |=> (running_q && (cur_q == '0) && !done_q && blk_nz[0]));

   // R4
   pkt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_o |-> (pkt_map_o != '0));

   // R6
   cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && (cnt_q != '0)) |=> $stable(cur_q));

   // R6
   ret_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && ret_valid_i) |->
         ({1'b0, cnt_q} + {1'b0, cnt_add} >= {1'b0, CNT_W'(lane_pop(ret_map_i))}));

   // R5
   ret_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid_i && !ret_exit_i) |->
         ((ret_base_i[OFS-1:0] == '0) && ((int'(ret_base_i) >> OFS) < WPB) &&
          (int'(ret_blk_i) < NUM_BLOCKS)));

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !pkt_valid_o));
endmodule

// File: tb/cvt_sched_tb.sv
module cvt_sched_tb;
   localparam int NB  = 8;
   localparam int WPB = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, req_i = 1'b0;
   logic        ret_valid_i = 1'b0, ret_exit_i = 1'b0;
   logic [2:0]  ret_blk_i = '0;
   logic [15:0] ret_base_i = '0;
   logic [63:0] ret_map_i = '0;
   logic        pkt_valid_o, busy_o, done_o;
   logic [15:0] pkt_base_o;
   logic [63:0] pkt_map_o;
   logic [2:0]  cur_blk_o;

   always #2 clk = ~clk;

   cvt_sched u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
      .pkt_valid_o(pkt_valid_o), .pkt_base_o(pkt_base_o), .pkt_map_o(pkt_map_o),
      .ret_valid_i(ret_valid_i), .ret_exit_i(ret_exit_i), .ret_blk_i(ret_blk_i),
      .ret_base_i(ret_base_i), .ret_map_i(ret_map_i),
      .cur_blk_o(cur_blk_o), .busy_o(busy_o), .done_o(done_o)
   );

   typedef struct {
      int          due;
      bit          none;
      logic [15:0] base;
      logic [63:0] map;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [63:0] mdl [NB][WPB];
   int          m_cur = 0;
   bit          m_busy = 0;
   int          pcnt = 0;
   int          total = 0, bad = 0;
   bit          finished = 0;

   localparam logic [63:0] ONES = '1;
   localparam logic [63:0] H = 64'h00000000FFFFFFFF;
   localparam logic [63:0] E = 64'h5555555555555555;
   localparam logic [63:0] P = 64'h1111111111111111;
   localparam logic [63:0] Q = 64'h4444444444444444;

   always @(posedge clk) pcnt <= pcnt + 1;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (sb.size() > 0 && sb[0].due == pcnt) begin
            exp_t e;
            e = sb.pop_front();
            if (e.none) begin
               chk({e.tag, " no packet"}, 64'(pkt_valid_o), 64'd0);
            end else begin
               chk({e.tag, " valid"}, 64'(pkt_valid_o), 64'd1);
               if (pkt_valid_o) begin
                  chk({e.tag, " base"}, 64'(pkt_base_o), 64'(e.base));
                  chk({e.tag, " map"}, pkt_map_o, e.map);
               end
            end
         end else if (pkt_valid_o) begin
            chk("R3 unexpected packet", 64'd1, 64'd0);
         end
      end
   end

   task automatic cyc(input bit req, input bit rv, input bit rx, input int rb,
                      input int rw, input logic [63:0] rm, input string tag);
      bit fwd;
      @(negedge clk);
      req_i = req; ret_valid_i = rv; ret_exit_i = rx;
      ret_blk_i = 3'(rb); ret_base_i = 16'(rw * 64); ret_map_i = rm;
      fwd = 0;
      if (req) begin
         exp_t e;
         int   w;
         w = -1;
         for (int i = WPB - 1; i >= 0; i--) if (mdl[m_cur][i] != '0) w = i;
         e.due = pcnt + 1; e.tag = tag;
         if (w < 0) begin
            e.none = 1; e.base = '0; e.map = '0;
         end else begin
            e.none = 0;
            e.base = 16'(w * 64);
            fwd = rv && !rx && (rb == m_cur) && (rw == w);
            e.map = mdl[m_cur][w] | (fwd ? rm : 64'd0);
            mdl[m_cur][w] = '0;
         end
         sb.push_back(e);
      end
      if (rv && !rx && !fwd) mdl[rb][rw] = mdl[rb][rw] | rm;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, '0, "idle");
   endtask

   task automatic do_start(input string tag);
      @(negedge clk);
      start_i = 1'b1; req_i = 1'b0; ret_valid_i = 1'b0;
      if (!m_busy) begin
         for (int w = 0; w < WPB; w++) mdl[0][w] = ONES;
         m_busy = 1; m_cur = 0;
      end
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // wait for the block to settle, then compare with the lowest non-empty model block
   task automatic expect_next(input string tag);
      int nb;
      idle(3);
      nb = -1;
      for (int b = NB - 1; b >= 0; b--)
         for (int w = 0; w < WPB; w++) if (mdl[b][w] != '0) nb = b;
      @(negedge clk);
      if (nb < 0) begin
         chk({tag, " done"}, 64'(done_o), 64'd1);
         chk({tag, " busy"}, 64'(busy_o), 64'd0);
         m_busy = 0;
      end else begin
         chk({tag, " busy"}, 64'(busy_o), 64'd1);
         chk({tag, " cur"}, 64'(cur_blk_o), 64'(nb));
         m_cur = nb;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < NB; b++) for (int w = 0; w < WPB; w++) mdl[b][w] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 64'(busy_o), 64'd0);
      chk("R1 done", 64'(done_o), 64'd0);
      chk("R1 valid", 64'(pkt_valid_o), 64'd0);
      chk("R1 cur", 64'(cur_blk_o), 64'd0);
      rst_n = 1'b1;
      idle(2);

      // R2 start fills block 0
      do_start("R2");
      chk("R2 busy", 64'(busy_o), 64'd1);
      chk("R2 cur", 64'(cur_blk_o), 64'd0);
      for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 0, '0, "R3 dispatch entry");
      // divergent successors
      cyc(0, 1, 0, 2, 0, H, "R5");
      cyc(0, 1, 0, 1, 0, ~H, "R5");
      for (int w = 1; w < WPB; w++) begin
         if (w == 2 || w == 5) begin
            cyc(0, 1, 0, 3, w, ONES, "R5");
         end else begin
            cyc(0, 1, 0, 1, w, E, "R5");
            if (w != 7) cyc(0, 1, 0, 3, w, ~E, "R5");
         end
      end
      idle(3);
      @(negedge clk);
      chk("R6 hold while outstanding", 64'(cur_blk_o), 64'd0);
      cyc(0, 1, 0, 3, 7, ~E, "R5");
      expect_next("R7 pick block 1");

      // block 1: skips, same-cycle merge, ignored start
      cyc(1, 0, 0, 0, 0, '0, "R3 blk1 w0");
      cyc(1, 0, 0, 0, 0, '0, "R3 blk1 w1");
      do_start("R10");
      cyc(0, 1, 0, 1, 1, P, "R5 loop part");
      cyc(1, 1, 0, 1, 1, Q, "R8 merge on read");
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, '0, "R4 skip empty");
      cyc(0, 1, 0, 0, 0, ~H, "R7 loop back");
      foreach (mdl[0][w]) if (w == 1 || w == 3 || w == 4 || w == 6 || w == 7)
         cyc(0, 1, 0, 3, w, E, "R5 converge");
      expect_next("R7 lower id");

      // block 0 again: R10 says the start above added nothing
      cyc(1, 0, 0, 0, 0, '0, "R10 blk0 upper half only");
      cyc(1, 0, 0, 0, 0, '0, "R10 no extra words");
      cyc(0, 1, 1, 0, 0, ~H, "R9 exit");
      expect_next("R7 pick block 2");
      cyc(1, 0, 0, 0, 0, '0, "R3 blk2");
      cyc(1, 0, 0, 0, 0, '0, "R3 blk2 empty");
      cyc(0, 1, 1, 0, 0, H, "R9 exit");
      expect_next("R7 pick block 3");
      for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, '0, "R5 merged words");
      for (int i = 0; i < 7; i++) cyc(0, 1, 1, 0, 0, ONES, "R9 exit");
      expect_next("R9 kernel end");
      idle(2);
      @(negedge clk);
      chk("R9 done sticky", 64'(done_o), 64'd1);

      // restart
      do_start("R2 restart");
      chk("R2 restart busy", 64'(busy_o), 64'd1);
      chk("R2 restart done", 64'(done_o), 64'd0);
      cyc(1, 0, 0, 0, 0, '0, "R2 restart w0");
      idle(3);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule